// File: doc/BRIEF.md
# Bank-Switched Memory Map Decoder

This block sits between an 8-bit processor bus with a 16-bit address and the physical ROM, main RAM and a small scratch RAM. Every memory access is translated through one of three memory maps. The address is first sorted into a window: low (0000-03FF), middle (0400-0FFF), upper-A (D800-E3FF), upper-B (E400-E7FF) or scratch (FC00-FCFF). The active map then picks a physical target and a base offset for that window. Reads and writes in each window have separate routes. This lets a window read ROM while its writes are dropped without touching any memory.

The active map is chosen as a side effect of an I/O read to port 5, 6 or 7. A reset, including a front-panel reset wired to `rst_n`, returns to map 0. Four write-enable switches protect the four 1 KB quarters of the 4 KB main RAM. The gating uses the physical RAM offset, bits 11:10. Memory strobes, addresses and the read-data return are combinational within the access cycle. The bus request uses a valid/ready pair. `bus_ready` is held high, so the decoder never applies back-pressure, and each cycle with `bus_valid` high completes one access.

Top module: `bank_map_decoder`

## Requirements
- R1: In map 0 (code 0), low and middle window reads return ROM at offset 0000 plus the address offset into 0000-0FFF. Upper-A reads return RAM from offset 0000, and upper-B reads return RAM from offset 0C00.
- R2: In map 0, writes to the low and middle windows change no memory. Writes to upper-A and upper-B land in RAM at the same offsets that reads use.
- R3: In map 1 (code 1), 0000-0FFF reads and writes RAM at the identical offset. Upper-A reads ROM from 0000 and upper-B reads ROM from 0C00, and writes to either upper window change no memory.
- R4: In map 2 (code 2), the low window reads ROM from 0C00 and its writes change no memory. The middle window reads and writes RAM from 0400. Upper-A reads ROM from 0000 with writes dropped. Upper-B reads and writes RAM from 0000.
- R5: Addresses FC00-FCFF read and write the 256-byte scratch RAM at offset address[7:0] in every map.
- R6: A memory read of any address outside the five windows returns 8'hFF, as does the bus data while no access is valid.
- R7: An I/O read (`bus_io`=1, `bus_write`=0) of port 5, 6 or 7 (address bits 7:0) selects map 0, 1 or 2 and returns 8'hFF. The new map applies from the next access cycle.
- R8: I/O writes, and I/O reads of any other port, leave the active map unchanged.
- R9: Reset forces map 0, whatever map was active before.
- R10: `wr_enable[q]`=0 blocks every write to main RAM whose physical offset has bits 11:10 equal to q, in every map and through every window.
- R11: `bus_ready` is high in every cycle, and no access stalls, including dropped and protected writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the front-panel reset |
| bus_valid | input | 1 | Access request valid |
| bus_ready | output | 1 | Access accepted (always high) |
| bus_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Memory address; bits 7:0 are the port for I/O |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data returned to the processor |
| wr_enable | input | 4 | Write-enable switch per 1 KB quarter of main RAM |
| rom_re | output | 1 | ROM read strobe |
| rom_addr | output | 12 | ROM physical offset |
| rom_rdata | input | 8 | ROM read data |
| ram_re | output | 1 | Main RAM read strobe |
| ram_we | output | 1 | Main RAM write strobe |
| ram_addr | output | 12 | Main RAM physical offset |
| ram_rdata | input | 8 | Main RAM read data |
| scr_re | output | 1 | Scratch RAM read strobe |
| scr_we | output | 1 | Scratch RAM write strobe |
| scr_addr | output | 8 | Scratch RAM offset |
| scr_rdata | input | 8 | Scratch RAM read data |
| mem_wdata | output | 8 | Write data toward the RAMs |

## Verification
Read data and strobes are due in the same cycle as the request. The bench drives each access just after a falling edge and samples `bus_rdata` 2 ns later, before the next rising edge. A write lands in memory at the rising edge that ends its cycle, and a map select takes effect at the rising edge of the I/O read. For that reason, every effect of a write or a map change is checked through a later, separate read cycle, often under a different map. Dropped and protected writes are checked by reading the location back through a map that exposes the RAM.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
  localparam int PHYS_AW  = 12;
  localparam int SCR_AW   = 8;
  localparam int MAP_CNT  = 3;
  localparam int WIN_CNT  = 4;

  typedef enum logic [1:0] {
    MAP_BOOT   = 2'd0,
    MAP_LOWRAM = 2'd1,
    MAP_SPLIT  = 2'd2
  } map_e;

  typedef enum logic [2:0] {
    RG_LO   = 3'd0,
    RG_MID  = 3'd1,
    RG_UPA  = 3'd2,
    RG_UPB  = 3'd3,
    RG_SCR  = 3'd4,
    RG_NONE = 3'd5
  } region_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_RAM  = 2'd2,
    TGT_SCR  = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e               tgt;
    logic [PHYS_AW-1:0] base;
  } route_t;

  localparam logic [15:0] WIN_FIRST [WIN_CNT] = '{16'h0000, 16'h0400, 16'hD800, 16'hE400};
  localparam logic [15:0] WIN_LAST  [WIN_CNT] = '{16'h03FF, 16'h0FFF, 16'hE3FF, 16'hE7FF};
  localparam logic [7:0]  SCR_PAGE  = 8'hFC;
endpackage

// File: rtl/bm_region_dec.sv
module bm_region_dec
  import bmap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]  addr,
  output region_e            region,
  output logic [PHYS_AW-1:0] offset
);
  logic [WIN_CNT-1:0] hit;
  logic [PHYS_AW-1:0] win_off [WIN_CNT];

  for (genvar g = 0; g < WIN_CNT; g++) begin : g_win
    logic [ADDR_W-1:0] diff;
    assign hit[g]     = (addr >= ADDR_W'(WIN_FIRST[g])) && (addr <= ADDR_W'(WIN_LAST[g]));
    assign diff       = addr - ADDR_W'(WIN_FIRST[g]);
    assign win_off[g] = diff[PHYS_AW-1:0];
  end

  always_comb begin
    region = RG_NONE;
    offset = '0;
    if (addr[ADDR_W-1 -: 8] == SCR_PAGE) begin
      region = RG_SCR;
      offset = PHYS_AW'(addr[SCR_AW-1:0]);
    end else begin
      for (int i = 0; i < WIN_CNT; i++) begin
        if (hit[i]) begin
          region = region_e'(3'(i));
          offset = win_off[i];
        end
      end
    end
  end
endmodule

// File: rtl/bm_route_table.sv
module bm_route_table
  import bmap_pkg::*;
(
  input  map_e    map_sel,
  input  region_e region,
  output route_t  rd_route,
  output route_t  wr_route
);
  localparam route_t DROP = '{tgt: TGT_NONE, base: '0};

  function automatic route_t mk(tgt_e t, logic [PHYS_AW-1:0] b);
    route_t r;
    r.tgt  = t;
    r.base = b;
    return r;
  endfunction

  always_comb begin
    rd_route = DROP;
    wr_route = DROP;
    if (region == RG_SCR) begin
      rd_route = mk(TGT_SCR, '0);
      wr_route = mk(TGT_SCR, '0);
    end else begin
      unique case (map_sel)
        MAP_LOWRAM: begin
          case (region)
            RG_LO:  begin rd_route = mk(TGT_RAM, 12'h000); wr_route = mk(TGT_RAM, 12'h000); end
            RG_MID: begin rd_route = mk(TGT_RAM, 12'h400); wr_route = mk(TGT_RAM, 12'h400); end
            RG_UPA: rd_route = mk(TGT_ROM, 12'h000);
            RG_UPB: rd_route = mk(TGT_ROM, 12'hC00);
            default: ;
          endcase
        end
        MAP_SPLIT: begin
          case (region)
            RG_LO:  rd_route = mk(TGT_ROM, 12'hC00);
            RG_MID: begin rd_route = mk(TGT_RAM, 12'h400); wr_route = mk(TGT_RAM, 12'h400); end
            RG_UPA: rd_route = mk(TGT_ROM, 12'h000);
            RG_UPB: begin rd_route = mk(TGT_RAM, 12'h000); wr_route = mk(TGT_RAM, 12'h000); end
            default: ;
          endcase
        end
        default: begin
          case (region)
            RG_LO:  rd_route = mk(TGT_ROM, 12'h000);
            RG_MID: rd_route = mk(TGT_ROM, 12'h400);
            RG_UPA: begin rd_route = mk(TGT_RAM, 12'h000); wr_route = mk(TGT_RAM, 12'h000); end
            RG_UPB: begin rd_route = mk(TGT_RAM, 12'hC00); wr_route = mk(TGT_RAM, 12'hC00); end
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/bm_wr_gate.sv
module bm_wr_gate #(
  parameter int Q_N = 4,
  localparam int QW = (Q_N > 1) ? $clog2(Q_N) : 1
) (
  input  logic [Q_N-1:0] wr_enable,
  input  logic [QW-1:0]  quarter,
  output logic           allow
);
  logic [Q_N-1:0] open_q;

  for (genvar g = 0; g < Q_N; g++) begin : g_q
    assign open_q[g] = wr_enable[g] && (quarter == QW'(g));
  end

  assign allow = |open_q;
endmodule

// File: rtl/bm_map_reg.sv
module bm_map_reg
  import bmap_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int SEL_BASE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_io,
  input  logic              acc_write,
  input  logic [PORT_W-1:0] port,
  output map_e              map_q
);
  logic              io_rd;
  logic [MAP_CNT-1:0] hit;
  logic [1:0]        code;

  assign io_rd = acc_valid && acc_io && !acc_write;

  for (genvar g = 0; g < MAP_CNT; g++) begin : g_sel
    assign hit[g] = io_rd && (port == PORT_W'(SEL_BASE + g));
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < MAP_CNT; i++) begin
      if (hit[i]) code = 2'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    map_q <= MAP_BOOT;
    else if (|hit) map_q <= map_e'(code);
  end

  // R7
  map_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && port >= PORT_W'(SEL_BASE) && port < PORT_W'(SEL_BASE + MAP_CNT))
      |=> (2'(map_q) == 2'($past(port) - PORT_W'(SEL_BASE))));

  // R8
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd || port < PORT_W'(SEL_BASE) || port >= PORT_W'(SEL_BASE + MAP_CNT))
      |=> $stable(map_q));

  // R9
  map_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (2'(map_q) < 2'(MAP_CNT)));
endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
  import bmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SW_N   = 4,
  localparam int QW    = (SW_N > 1) ? $clog2(SW_N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  output logic               bus_ready,
  input  logic               bus_io,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [SW_N-1:0]    wr_enable,
  output logic               rom_re,
  output logic [PHYS_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0]  rom_rdata,
  output logic               ram_re,
  output logic               ram_we,
  output logic [PHYS_AW-1:0] ram_addr,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic               scr_re,
  output logic               scr_we,
  output logic [SCR_AW-1:0]  scr_addr,
  input  logic [DATA_W-1:0]  scr_rdata,
  output logic [DATA_W-1:0]  mem_wdata
);
  map_e               map_q;
  region_e            region;
  logic [PHYS_AW-1:0] win_off;
  route_t             rd_route, wr_route, act;
  logic [PHYS_AW-1:0] phys;
  logic               mem_acc, ram_ok;

  bm_map_reg #(.PORT_W(8), .SEL_BASE(5)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (bus_valid),
    .acc_io    (bus_io),
    .acc_write (bus_write),
    .port      (bus_addr[7:0]),
    .map_q     (map_q)
  );

  bm_region_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .region (region),
    .offset (win_off)
  );

  bm_route_table u_tbl (
    .map_sel  (map_q),
    .region   (region),
    .rd_route (rd_route),
    .wr_route (wr_route)
  );

  assign act     = bus_write ? wr_route : rd_route;
  assign phys    = act.base + win_off;
  assign mem_acc = bus_valid && !bus_io;

  bm_wr_gate #(.Q_N(SW_N)) u_gate (
    .wr_enable (wr_enable),
    .quarter   (phys[PHYS_AW-1 -: QW]),
    .allow     (ram_ok)
  );

  assign bus_ready = 1'b1;
  assign rom_re    = mem_acc && !bus_write && (act.tgt == TGT_ROM);
  assign ram_re    = mem_acc && !bus_write && (act.tgt == TGT_RAM);
  assign ram_we    = mem_acc &&  bus_write && (act.tgt == TGT_RAM) && ram_ok;
  assign scr_re    = mem_acc && !bus_write && (act.tgt == TGT_SCR);
  assign scr_we    = mem_acc &&  bus_write && (act.tgt == TGT_SCR);
  assign rom_addr  = phys;
  assign ram_addr  = phys;
  assign scr_addr  = phys[SCR_AW-1:0];
  assign mem_wdata = bus_wdata;

  always_comb begin
    if (rom_re)      bus_rdata = rom_rdata;
    else if (ram_re) bus_rdata = ram_rdata;
    else if (scr_re) bus_rdata = scr_rdata;
    else             bus_rdata = '1;
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_re, ram_re, ram_we, scr_re, scr_we}));

  // R10
  wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> wr_enable[ram_addr[PHYS_AW-1 -: QW]]);

  // R5
  scratch_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_acc && bus_addr[ADDR_W-1 -: 8] == SCR_PAGE)
      |-> ((scr_re || scr_we) && scr_addr == bus_addr[SCR_AW-1:0]));

  // R6
  unmapped_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_re && !ram_re && !scr_re) |-> (bus_rdata == '1));

  // R7
  io_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_io) |-> (bus_rdata == '1 && !ram_we && !scr_we));

  // R11
  no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_ready);
endmodule

// File: tb/test_bank_map_decoder.sv
module test_bank_map_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_io = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [3:0]  wr_enable = 4'hF;
  logic bus_ready, rom_re, ram_re, ram_we, scr_re, scr_we;
  logic [7:0]  bus_rdata, rom_rdata, ram_rdata, scr_rdata, mem_wdata, scr_addr;
  logic [11:0] rom_addr, ram_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] romval(int i);
    return 8'((i * 13) ^ (i >> 4));
  endfunction
  function automatic logic [7:0] ramval(int i);
    return 8'((i * 7) ^ (i >> 5) ^ 8'hA5);
  endfunction
  function automatic logic [7:0] scrval(int i);
    return 8'(i + 8'h40);
  endfunction

  logic [7:0] ram [4096];
  logic [7:0] scr [256];
  initial begin
    for (int i = 0; i < 4096; i++) ram[i] = ramval(i);
    for (int i = 0; i < 256; i++) scr[i] = scrval(i);
  end
  always @(posedge clk) begin
    if (ram_we) ram[ram_addr] <= mem_wdata;
    if (scr_we) scr[scr_addr] <= mem_wdata;
  end
  assign rom_rdata = romval(int'(rom_addr));
  assign ram_rdata = ram[ram_addr];
  assign scr_rdata = scr[scr_addr];

  bank_map_decoder i_bank_map_decoder (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_io(bus_io), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_enable(wr_enable),
    .rom_re(rom_re), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .scr_re(scr_re), .scr_we(scr_we), .scr_addr(scr_addr), .scr_rdata(scr_rdata),
    .mem_wdata(mem_wdata)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic cpu_rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_io = 1'b0; bus_write = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic cpu_wr(logic [15:0] a, logic [7:0] v);
    @(negedge clk);
    bus_valid = 1'b1; bus_io = 1'b0; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
    @(posedge clk);
  endtask

  task automatic io_rd(logic [7:0] p, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_io = 1'b1; bus_write = 1'b0; bus_addr = {8'h00, p};
    #2 d = bus_rdata;
  endtask

  task automatic io_wr(logic [7:0] p, logic [7:0] v);
    @(negedge clk);
    bus_valid = 1'b1; bus_io = 1'b1; bus_write = 1'b1; bus_addr = {8'h00, p}; bus_wdata = v;
    @(posedge clk);
  endtask

  task automatic set_map(int m);
    logic [7:0] d;
    io_rd(8'(5 + m), d);
  endtask

  // {map[31:30], addr[29:14], kind[13:12], off[11:0]}; kind 0 ROM, 1 RAM, 2 scratch, 3 all-ones
  localparam int NV = 26;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 16'h0000, 2'd0, 12'h000}, {2'd0, 16'h03FF, 2'd0, 12'h3FF},
    {2'd0, 16'h0400, 2'd0, 12'h400}, {2'd0, 16'h0FFF, 2'd0, 12'hFFF},
    {2'd0, 16'hD800, 2'd1, 12'h000}, {2'd0, 16'hE3FF, 2'd1, 12'hBFF},
    {2'd0, 16'hE400, 2'd1, 12'hC00}, {2'd0, 16'hE7FF, 2'd1, 12'hFFF},
    {2'd0, 16'h1000, 2'd3, 12'h000},
    {2'd1, 16'h0000, 2'd1, 12'h000}, {2'd1, 16'h0ABC, 2'd1, 12'hABC},
    {2'd1, 16'hD800, 2'd0, 12'h000}, {2'd1, 16'hE3FF, 2'd0, 12'hBFF},
    {2'd1, 16'hE400, 2'd0, 12'hC00}, {2'd1, 16'hE7FF, 2'd0, 12'hFFF},
    {2'd1, 16'hFC10, 2'd2, 12'h010}, {2'd1, 16'hD7FF, 2'd3, 12'h000},
    {2'd2, 16'h0000, 2'd0, 12'hC00}, {2'd2, 16'h03FF, 2'd0, 12'hFFF},
    {2'd2, 16'h0400, 2'd1, 12'h400}, {2'd2, 16'h0FFF, 2'd1, 12'hFFF},
    {2'd2, 16'hD800, 2'd0, 12'h000}, {2'd2, 16'hE400, 2'd1, 12'h000},
    {2'd2, 16'hE7FF, 2'd1, 12'h3FF}, {2'd2, 16'hFD00, 2'd3, 12'h000},
    {2'd2, 16'hFCFF, 2'd2, 12'h0FF}
  };

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] d, e;
    string tag;
    repeat (3) @(negedge clk);
    #2;
    check("R11 ready after reset", 8'(bus_ready), 8'h01);
    check("R6 idle bus data", bus_rdata, 8'hFF);
    @(negedge clk) rst_n = 1'b1;
    cpu_rd(16'h0123, d); check("R9 map0 after reset", d, romval(12'h123));

    for (int k = 0; k < NV; k++) begin
      logic [31:0] v;
      v = VEC[k];
      set_map(int'(v[31:30]));
      cpu_rd(v[29:14], d);
      case (v[13:12])
        2'd0: e = romval(int'(v[11:0]));
        2'd1: e = ramval(int'(v[11:0]));
        2'd2: e = scrval(int'(v[7:0]));
        default: e = 8'hFF;
      endcase
      if (v[13:12] == 2'd2)      tag = "R5 scratch window";
      else if (v[13:12] == 2'd3) tag = "R6 unmapped read";
      else if (v[31:30] == 2'd0) tag = "R1 map0 read";
      else if (v[31:30] == 2'd1) tag = "R3 map1 read";
      else                       tag = "R4 map2 read";
      check(tag, d, e);
    end

    // R7: select by I/O read, value all ones, effect on next access
    set_map(0);
    io_rd(8'd6, d); check("R7 io read value", d, 8'hFF);
    cpu_rd(16'h0010, d); check("R7 map1 active next cycle", d, ramval(12'h010));
    // R8: other I/O traffic leaves map unchanged
    io_wr(8'd5, 8'h00);
    cpu_rd(16'h0010, d); check("R8 io write ignored", d, ramval(12'h010));
    io_rd(8'd8, d);
    cpu_rd(16'h0010, d); check("R8 io read port 8 ignored", d, ramval(12'h010));
    io_rd(8'd4, d);
    cpu_rd(16'h0010, d); check("R8 io read port 4 ignored", d, ramval(12'h010));

    // R3 writes
    cpu_wr(16'h0020, 8'h9E);
    cpu_rd(16'h0020, d); check("R3 map1 low RAM write", d, 8'h9E);
    cpu_wr(16'hD810, 8'h11);
    set_map(0);
    cpu_rd(16'hD810, d); check("R3 map1 upper write dropped", d, ramval(12'h010));

    // R2 writes
    cpu_wr(16'h0030, 8'h44);
    cpu_rd(16'h0030, d); check("R2 map0 ROM still read", d, romval(12'h030));
    cpu_wr(16'hD840, 8'h5B);
    cpu_rd(16'hD840, d); check("R2 map0 upper-A write", d, 8'h5B);
    cpu_wr(16'hE450, 8'h5C);
    set_map(1);
    cpu_rd(16'h0030, d); check("R2 map0 low write dropped", d, ramval(12'h030));
    cpu_rd(16'h0040, d); check("R2 upper-A lands at RAM 040", d, 8'h5B);
    cpu_rd(16'h0C50, d); check("R2 upper-B lands at RAM C50", d, 8'h5C);

    // R4 writes
    set_map(2);
    cpu_wr(16'h0500, 8'h61);
    cpu_rd(16'h0500, d); check("R4 map2 middle write", d, 8'h61);
    cpu_wr(16'h0100, 8'h62);
    cpu_wr(16'hD900, 8'h64);
    cpu_wr(16'hE420, 8'h63);
    set_map(1);
    cpu_rd(16'h0100, d); check("R4 map2 low write dropped", d, ramval(12'h100));
    cpu_rd(16'h0020, d); check("R4 map2 upper-B lands at RAM 020", d, 8'h63);
    set_map(0);
    cpu_rd(16'hD900, d); check("R4 map2 upper-A write dropped", d, ramval(12'h100));

    // R10 write protection by physical quarter
    wr_enable = 4'b1011;
    set_map(1);
    cpu_wr(16'h0800, 8'h71);
    cpu_rd(16'h0800, d); check("R10 quarter 2 protected", d, ramval(12'h800));
    cpu_wr(16'h0C05, 8'h72);
    cpu_rd(16'h0C05, d); check("R10 quarter 3 open", d, 8'h72);
    wr_enable = 4'b0111;
    set_map(0);
    cpu_wr(16'hE410, 8'h73);
    set_map(1);
    cpu_rd(16'h0C10, d); check("R10 quarter 3 protected via upper-B", d, ramval(12'hC10));
    wr_enable = 4'hF;

    // R5 scratch writes independent of map
    set_map(2);
    cpu_wr(16'hFC20, 8'h5A);
    set_map(0);
    cpu_rd(16'hFC20, d); check("R5 scratch across maps", d, 8'h5A);
    cpu_rd(16'hFC21, d); check("R5 scratch neighbour", d, scrval(8'h21));

    // R9 reset from map 2
    set_map(2);
    cpu_rd(16'h0000, d); check("R4 map2 before reset", d, romval(12'hC00));
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk) rst_n = 1'b1;
    cpu_rd(16'h0000, d); check("R9 reset restores map0 low", d, romval(12'h000));
    cpu_rd(16'hE400, d); check("R9 reset restores map0 upper-B", d, ramval(12'hC00));
    check("R11 ready during access", 8'(bus_ready), 8'h01);

    @(negedge clk) bus_valid = 1'b0;
    #2 check("R6 idle data all ones", bus_rdata, 8'hFF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule